// File: doc/BRIEF.md
# Tile-Mapped Text Video Controller

This block produces a monochrome raster picture from a grid of character cells. A bus master reaches video memory through an 8-bit Wishbone device port. The low part of the address space is the cell map, with one tile index per cell. The window above it holds 256 tile bitmaps of 8x8 pixels. Each bitmap row is one byte, and bit 7 is the leftmost pixel.

An internal raster counter runs one pixel every `CLK_PER_PIX` bus clocks. With the defaults this gives a 640x480 frame from a 50 MHz clock. For each pixel the block reads the tile index of the current cell, then the bitmap row for the current scan line, and then selects one bit. Sync and blanking are delayed by the same number of pixel steps as the memory reads, so the pixel bit and the sync pulses stay aligned. The screen is black wherever the raster is outside the visible area.

Top module: `tile_video_ctrl`

## Requirements
- R1: While reset (`rst_ni` low, sampled on the clock) is held, `ack_o` and `pix_o` are 0, and `hsync_o` and `vsync_o` are 1 (inactive).
- R2: When `cyc_i` and `stb_i` are both high and `ack_o` is low, `ack_o` is high in the next cycle for exactly one cycle. In the cycle after that it is low, even if the request is still held.
- R3: Addresses from 0 up to COLS*ROWS-1 (COLS = H_ACTIVE/8, ROWS = V_ACTIVE/8) store one byte per cell and read back what was written. Addresses from COLS*ROWS up to 0x1FFF read 0 and ignore writes.
- R4: Address 0x2000 + 8*n + r holds row r (0 = top) of tile n. It reads back what was written.
- R5: Addresses 0x2800 and above read 0, and writes to them change nothing.
- R6: At power-up, row r of tile n holds (n XOR ((37*r) mod 256)) for codes 33 to 126, and 0 for every other code.
- R7: Raster positions run h = 0..H_TOTAL-1 per line and v = 0..V_TOTAL-1 per frame. `hsync_o` is low for h in [H_ACTIVE+H_FRONT, H_ACTIVE+H_FRONT+H_SYNC). `vsync_o` is low for v in [V_ACTIVE+V_FRONT, V_ACTIVE+V_FRONT+V_SYNC).
- R8: At a visible position (h, v), the pixel is bit (7 - h mod 8) of row (v mod 8) of the tile whose index is stored at cell address (v/8)*COLS + h/8.
- R9: `pix_o` is 0 at every position with h >= H_ACTIVE or v >= V_ACTIVE.
- R10: `pix_o`, `hsync_o` and `vsync_o` show raster position k at the third pixel step after position k. All three carry the same delay.
- R11: The raster advances once every `CLK_PER_PIX` clocks. The first step falls on the `CLK_PER_PIX`-th clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and video clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cyc_i | input | 1 | Wishbone cycle |
| stb_i | input | 1 | Wishbone strobe |
| we_i | input | 1 | Wishbone write enable |
| adr_i | input | 14 | Wishbone byte address |
| dat_i | input | 8 | Wishbone write data |
| dat_o | output | 8 | Wishbone read data, valid while `ack_o` is high |
| ack_o | output | 1 | Wishbone acknowledge |
| pix_o | output | 1 | Pixel bit, 1 = lit |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
The bench builds the block with a 32x16 visible area (a 4x2 cell grid), front porches of 2 pixels and 1 line, syncs of 4 pixels and 2 lines, back porches of 2 pixels and 1 line, and two clocks per pixel. A whole 1600-clock frame therefore runs many times in a short simulation. The small grid also places the end of the cell map at address 8, so the cells beyond the grid are easy to reach. A bench model of the raster and of both memories predicts all three video outputs on every clock. This covers sync placement, blanking, MSB-first bit order and pipeline alignment for several cell contents, including a tile rewritten over the bus.

// File: rtl/tvc_pkg.sv
// tvc_pkg: shared constants, types and the power-up tile pattern for the
// tile-mapped video controller. Assumes an 8-bit bus and 8x8 tiles.
package tvc_pkg;

    localparam int unsigned TILE_ROWS  = 8;
    localparam int unsigned TILE_COUNT = 256;
    localparam int unsigned TILE_BYTES = TILE_ROWS * TILE_COUNT;
    localparam int unsigned TILE_AW    = $clog2(TILE_BYTES);

    localparam logic [13:0] TILE_BASE  = 14'h2000;
    localparam logic [13:0] TILE_LIMIT = 14'h2800;

    // Raster information carried with the first pipeline stage
    typedef struct packed {
        logic       active;
        logic       hs_n;
        logic       vs_n;
        logic [2:0] xs;
        logic [2:0] ys;
    } raster_t;

    // Which memory answered the pending bus access
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SCR  = 2'd1,
        SRC_TILE = 2'd2
    } rd_src_e;

    // Power-up bitmap row: a stand-in glyph for printable codes only
    function automatic logic [7:0] preload_row(input int unsigned code,
                                               input int unsigned row);
        logic [7:0] v;
        if (code >= 33 && code <= 126)
            v = 8'(code ^ ((row * 37) & 255));
        else
            v = 8'h00;
        return v;
    endfunction

endpackage

// File: rtl/tvc_raster.sv
// tvc_raster: pixel-enable divider plus horizontal and vertical position
// counters. Produces the raster flags for the current position.
// Assumes CLK_PER_PIX >= 1 and blanking-interval lengths >= 1.
module tvc_raster
    import tvc_pkg::*;
#(
    parameter int unsigned H_ACTIVE    = 640,
    parameter int unsigned H_FRONT     = 16,
    parameter int unsigned H_SYNC      = 96,
    parameter int unsigned H_BACK      = 48,
    parameter int unsigned V_ACTIVE    = 480,
    parameter int unsigned V_FRONT     = 10,
    parameter int unsigned V_SYNC      = 2,
    parameter int unsigned V_BACK      = 33,
    parameter int unsigned CLK_PER_PIX = 2,
    localparam int unsigned H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int unsigned V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int unsigned HW      = $clog2(H_TOTAL),
    localparam int unsigned VW      = $clog2(V_TOTAL)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic          pix_en_o,
    output logic [HW-1:0] hpos_o,
    output logic [VW-1:0] vpos_o,
    output raster_t       info_o
);

    localparam int unsigned DW = (CLK_PER_PIX > 1) ? $clog2(CLK_PER_PIX) : 1;

    localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS    = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_VIS    = VW'(V_ACTIVE);
    localparam logic [HW-1:0] HS_START = HW'(H_ACTIVE + H_FRONT);
    localparam logic [HW-1:0] HS_END   = HW'(H_ACTIVE + H_FRONT + H_SYNC);
    localparam logic [VW-1:0] VS_START = VW'(V_ACTIVE + V_FRONT);
    localparam logic [VW-1:0] VS_END   = VW'(V_ACTIVE + V_FRONT + V_SYNC);

    logic [DW-1:0] div_q;
    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;

    generate
        if (CLK_PER_PIX > 1) begin : g_div
            // Count clocks within one pixel period
            always_ff @(posedge clk_i) begin
                if (!rst_ni)       div_q <= '0;
                else if (pix_en_o) div_q <= '0;
                else               div_q <= div_q + 1'b1;
            end
            assign pix_en_o = (div_q == DW'(CLK_PER_PIX - 1));
        end else begin : g_nodiv
            // One pixel per clock: the divider stays idle
            always_ff @(posedge clk_i) begin
                div_q <= '0;
            end
            assign pix_en_o = 1'b1;
        end
    endgenerate

    // Step the raster position once per pixel enable
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            h_q <= '0;
            v_q <= '0;
        end else if (pix_en_o) begin
            if (h_q == H_LAST) begin
                h_q <= '0;
                v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
            end else begin
                h_q <= h_q + 1'b1;
            end
        end
    end

    // Derive visibility and sync flags for the current position
    always_comb begin
        info_o.active = (h_q < H_VIS) && (v_q < V_VIS);
        info_o.hs_n   = !((h_q >= HS_START) && (h_q < HS_END));
        info_o.vs_n   = !((v_q >= VS_START) && (v_q < VS_END));
        info_o.xs     = h_q[2:0];
        info_o.ys     = v_q[2:0];
    end

    assign hpos_o = h_q;
    assign vpos_o = v_q;

endmodule

// File: rtl/tvc_vram.sv
// tvc_vram: byte-wide memory with a read/write bus port and a read-only
// video port, both registered. PRELOAD selects power-up tile content.
// Assumes DEPTH >= 2.
module tvc_vram
    import tvc_pkg::*;
#(
    parameter int unsigned DEPTH   = 2048,
    parameter bit          PRELOAD = 1'b0,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          a_en_i,
    input  logic          a_we_i,
    input  logic [AW-1:0] a_addr_i,
    input  logic [7:0]    a_wdata_i,
    output logic [7:0]    a_rdata_o,
    input  logic          b_en_i,
    input  logic [AW-1:0] b_addr_i,
    output logic [7:0]    b_rdata_o
);

    logic [7:0] mem [DEPTH];

    generate
        if (PRELOAD) begin : g_tiles
            // Fill with the built-in tile pattern at power-up
            initial begin
                for (int i = 0; i < int'(DEPTH); i++)
                    mem[i] = preload_row(i / TILE_ROWS, i % TILE_ROWS);
            end
        end else begin : g_blank
            // Start with an empty memory
            initial begin
                for (int i = 0; i < int'(DEPTH); i++)
                    mem[i] = 8'h00;
            end
        end
    endgenerate

    // Bus port: read the old value, write when requested
    always_ff @(posedge clk_i) begin
        if (a_en_i) begin
            if (a_we_i) mem[a_addr_i] <= a_wdata_i;
            a_rdata_o <= mem[a_addr_i];
        end
    end

    // Video port: registered read on each pixel step
    always_ff @(posedge clk_i) begin
        if (b_en_i) b_rdata_o <= mem[b_addr_i];
    end

endmodule

// File: rtl/tvc_bus_port.sv
// tvc_bus_port: Wishbone device decode. One-cycle acknowledge, single
// beat per request, memory strobes for the cell map and tile window.
// Assumes SCR_DEPTH <= 0x2000.
module tvc_bus_port
    import tvc_pkg::*;
#(
    parameter int unsigned SCR_DEPTH = 4800,
    localparam int unsigned SCR_AW   = $clog2(SCR_DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [13:0]       adr_i,
    input  logic [7:0]        dat_i,
    output logic [7:0]        dat_o,
    output logic              ack_o,
    output logic              scr_en_o,
    output logic              tile_en_o,
    output logic              we_o,
    output logic [SCR_AW-1:0] scr_addr_o,
    output logic [TILE_AW-1:0] tile_addr_o,
    output logic [7:0]        wdata_o,
    input  logic [7:0]        scr_rdata_i,
    input  logic [7:0]        tile_rdata_i
);

    logic    req;
    logic    hit_scr;
    logic    hit_tile;
    rd_src_e src_q;

    // Accept a request only when no acknowledge is in flight
    always_comb begin
        req      = cyc_i && stb_i && !ack_o;
        hit_scr  = (32'(adr_i) < SCR_DEPTH) && (adr_i < TILE_BASE);
        hit_tile = (adr_i >= TILE_BASE) && (adr_i < TILE_LIMIT);
    end

    assign scr_en_o    = req && hit_scr;
    assign tile_en_o   = req && hit_tile;
    assign we_o        = we_i;
    assign scr_addr_o  = adr_i[SCR_AW-1:0];
    assign tile_addr_o = adr_i[TILE_AW-1:0];
    assign wdata_o     = dat_i;

    // Raise the acknowledge and remember the answering memory
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ack_o <= 1'b0;
            src_q <= SRC_NONE;
        end else begin
            ack_o <= req;
            if (req)
                src_q <= hit_scr ? SRC_SCR : (hit_tile ? SRC_TILE : SRC_NONE);
        end
    end

    // Return the answering memory's byte, zero for unmapped addresses
    always_comb begin
        unique case (src_q)
            SRC_SCR:  dat_o = scr_rdata_i;
            SRC_TILE: dat_o = tile_rdata_i;
            default:  dat_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/tvc_pixel_pipe.sv
// tvc_pixel_pipe: carries raster flags alongside the cell-index read and the
// bitmap-row read, then picks the pixel bit (MSB leftmost) and registers it
// with the delayed syncs. Advances only on the pixel enable.
module tvc_pixel_pipe
    import tvc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pix_en_i,
    input  raster_t            info_i,
    input  logic [7:0]         idx_i,
    input  logic [7:0]         bmp_i,
    output logic [TILE_AW-1:0] tile_raddr_o,
    output logic               pix_o,
    output logic               hsync_o,
    output logic               vsync_o
);

    raster_t    s1_q;
    logic       s2_active_q;
    logic       s2_hs_n_q;
    logic       s2_vs_n_q;
    logic [2:0] s2_xs_q;

    assign tile_raddr_o = {idx_i, s1_q.ys};

    // Stage 1: flags wait for the cell-index read
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            s1_q <= '{active: 1'b0, hs_n: 1'b1, vs_n: 1'b1, xs: 3'd0, ys: 3'd0};
        else if (pix_en_i)
            s1_q <= info_i;
    end

    // Stage 2: flags wait for the bitmap-row read
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s2_active_q <= 1'b0;
            s2_hs_n_q   <= 1'b1;
            s2_vs_n_q   <= 1'b1;
            s2_xs_q     <= 3'd0;
        end else if (pix_en_i) begin
            s2_active_q <= s1_q.active;
            s2_hs_n_q   <= s1_q.hs_n;
            s2_vs_n_q   <= s1_q.vs_n;
            s2_xs_q     <= s1_q.xs;
        end
    end

    // Output stage: select the bit, blank outside the visible area
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pix_o   <= 1'b0;
            hsync_o <= 1'b1;
            vsync_o <= 1'b1;
        end else if (pix_en_i) begin
            pix_o   <= s2_active_q && bmp_i[~s2_xs_q];
            hsync_o <= s2_hs_n_q;
            vsync_o <= s2_vs_n_q;
        end
    end

endmodule

// File: rtl/tile_video_ctrl.sv
// tile_video_ctrl: tile-mapped monochrome video controller with a Wishbone
// device port. Cell map at 0x0000, tile bitmaps at 0x2000..0x27FF.
// Assumes H_ACTIVE and V_ACTIVE are multiples of 8 and the grid has at most
// 8192 cells.
module tile_video_ctrl
    import tvc_pkg::*;
#(
    parameter int unsigned H_ACTIVE    = 640,
    parameter int unsigned H_FRONT     = 16,
    parameter int unsigned H_SYNC      = 96,
    parameter int unsigned H_BACK      = 48,
    parameter int unsigned V_ACTIVE    = 480,
    parameter int unsigned V_FRONT     = 10,
    parameter int unsigned V_SYNC      = 2,
    parameter int unsigned V_BACK      = 33,
    parameter int unsigned CLK_PER_PIX = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cyc_i,
    input  logic        stb_i,
    input  logic        we_i,
    input  logic [13:0] adr_i,
    input  logic [7:0]  dat_i,
    output logic [7:0]  dat_o,
    output logic        ack_o,
    output logic        pix_o,
    output logic        hsync_o,
    output logic        vsync_o
);

    localparam int unsigned COLS      = H_ACTIVE / TILE_ROWS;
    localparam int unsigned ROWS      = V_ACTIVE / TILE_ROWS;
    localparam int unsigned SCR_DEPTH = COLS * ROWS;
    localparam int unsigned SCR_AW    = $clog2(SCR_DEPTH);
    localparam int unsigned H_TOTAL   = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int unsigned V_TOTAL   = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int unsigned HW        = $clog2(H_TOTAL);
    localparam int unsigned VW        = $clog2(V_TOTAL);

    logic                pix_en;
    logic [HW-1:0]       hpos;
    logic [VW-1:0]       vpos;
    raster_t             info;
    logic [SCR_AW-1:0]   cell_addr;

    logic                scr_en, tile_en, bus_we;
    logic [SCR_AW-1:0]   bus_scr_addr;
    logic [TILE_AW-1:0]  bus_tile_addr;
    logic [7:0]          bus_wdata, scr_rdata, tile_rdata;
    logic [7:0]          cell_idx, bmp_row;
    logic [TILE_AW-1:0]  tile_raddr;

    tvc_raster #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
        .CLK_PER_PIX(CLK_PER_PIX)
    ) u_raster (
        .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_o(pix_en),
        .hpos_o(hpos), .vpos_o(vpos), .info_o(info)
    );

    // Cell address of the current position; 0 while blanked
    always_comb begin
        if (info.active)
            cell_addr = SCR_AW'(vpos >> 3) * SCR_AW'(COLS) + SCR_AW'(hpos >> 3);
        else
            cell_addr = '0;
    end

    tvc_bus_port #(.SCR_DEPTH(SCR_DEPTH)) u_bus (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i),
        .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
        .scr_en_o(scr_en), .tile_en_o(tile_en), .we_o(bus_we),
        .scr_addr_o(bus_scr_addr), .tile_addr_o(bus_tile_addr),
        .wdata_o(bus_wdata), .scr_rdata_i(scr_rdata), .tile_rdata_i(tile_rdata)
    );

    tvc_vram #(.DEPTH(SCR_DEPTH), .PRELOAD(1'b0)) u_scr (
        .clk_i(clk_i),
        .a_en_i(scr_en), .a_we_i(bus_we), .a_addr_i(bus_scr_addr),
        .a_wdata_i(bus_wdata), .a_rdata_o(scr_rdata),
        .b_en_i(pix_en), .b_addr_i(cell_addr), .b_rdata_o(cell_idx)
    );

    tvc_vram #(.DEPTH(TILE_BYTES), .PRELOAD(1'b1)) u_tiles (
        .clk_i(clk_i),
        .a_en_i(tile_en), .a_we_i(bus_we), .a_addr_i(bus_tile_addr),
        .a_wdata_i(bus_wdata), .a_rdata_o(tile_rdata),
        .b_en_i(pix_en), .b_addr_i(tile_raddr), .b_rdata_o(bmp_row)
    );

    tvc_pixel_pipe u_pipe (
        .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en), .info_i(info),
        .idx_i(cell_idx), .bmp_i(bmp_row), .tile_raddr_o(tile_raddr),
        .pix_o(pix_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
    );

endmodule

// File: rtl/tvc_checker.sv
// tvc_checker: port-level properties of tile_video_ctrl, bound to the top.
module tvc_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        cyc_i,
    input logic        stb_i,
    input logic        we_i,
    input logic [13:0] adr_i,
    input logic [7:0]  dat_o,
    input logic        ack_o,
    input logic        pix_o,
    input logic        hsync_o,
    input logic        vsync_o
);

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_i && stb_i && !ack_o) |=> ack_o); // R2

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o); // R2

    AST_ACK_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> $past(cyc_i && stb_i)); // R2

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && $past(!we_i && (adr_i >= 14'h2800))) |-> (dat_o == 8'h00)); // R5

    AST_DARK_DURING_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hsync_o || !vsync_o) |-> !pix_o); // R9

endmodule

bind tile_video_ctrl tvc_checker u_tvc_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i),
    .we_i(we_i), .adr_i(adr_i), .dat_o(dat_o), .ack_o(ack_o),
    .pix_o(pix_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
);

// File: tb/tb_tile_video_ctrl.sv
// tb_tile_video_ctrl: bus-level directed checks plus a per-clock raster and
// memory model that predicts every video output.
module tb_tile_video_ctrl;

    localparam int HA = 32, HF = 2, HS = 4, HB = 2;
    localparam int VA = 16, VF = 1, VS = 2, VB = 1;
    localparam int CPP = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int COLS = HA / 8;
    localparam int NCELL = COLS * (VA / 8);
    localparam logic [2:0] IDLE = 3'b011; // {pix, hsync, vsync}

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [13:0] adr = '0;
    logic [7:0] wd = '0;
    logic [7:0] dat_o;
    logic ack, pix, hsync, vsync;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tile_video_ctrl #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
        .CLK_PER_PIX(CPP)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
        .adr_i(adr), .dat_i(wd), .dat_o(dat_o), .ack_o(ack),
        .pix_o(pix), .hsync_o(hsync), .vsync_o(vsync)
    );

    // Reference memories
    logic [7:0] m_scr [NCELL];
    logic [7:0] m_tile [2048];

    function automatic logic [7:0] glyph(int n, int r);
        if (n >= 33 && n <= 126) return 8'(n ^ ((37 * r) % 256));
        return 8'h00;
    endfunction

    initial begin
        for (int i = 0; i < NCELL; i++) m_scr[i] = 8'h00;
        for (int i = 0; i < 2048; i++) m_tile[i] = glyph(i / 8, i % 8);
    end

    function automatic logic [2:0] expect_at(int h, int v);
        logic p, hs_n, vs_n;
        logic [7:0] row;
        hs_n = !(h >= HA + HF && h < HA + HF + HS);
        vs_n = !(v >= VA + VF && v < VA + VF + VS);
        p = 1'b0;
        if (h < HA && v < VA) begin
            row = m_tile[m_scr[(v / 8) * COLS + h / 8] * 8 + v % 8];
            p = row[7 - h % 8];
        end
        return {p, hs_n, vs_n};
    endfunction

    // Raster model: outputs lag the raster by two steps plus the output register
    int m_div, m_h, m_v;
    logic [2:0] q0, q1, exp_out;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_h = 0; m_v = 0;
            q0 = IDLE; q1 = IDLE; exp_out = IDLE;
        end else if (m_div == CPP - 1) begin
            m_div = 0;
            exp_out = q0;
            q0 = q1;
            q1 = expect_at(m_h, m_v);
            if (m_h == HT - 1) begin
                m_h = 0;
                m_v = (m_v == VT - 1) ? 0 : m_v + 1;
            end else begin
                m_h = m_h + 1;
            end
        end else begin
            m_div = m_div + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // Per-clock comparison of the video outputs (R7, R8, R9, R10, R11)
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R8/R9/R10 pixel", {31'd0, pix}, {31'd0, exp_out[2]});
            check("R7/R10 hsync", {31'd0, hsync}, {31'd0, exp_out[1]});
            check("R7/R10 vsync", {31'd0, vsync}, {31'd0, exp_out[0]});
        end
    end

    task automatic bus(input logic w, input logic [13:0] a, input logic [7:0] d,
                       output logic [7:0] r);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wd = d;
        @(negedge clk);
        check("R2 ack raised", {31'd0, ack}, 32'd1);
        r = dat_o;
        if (w) begin
            if (int'(a) < NCELL) m_scr[a] = d;
            else if (a >= 14'h2000 && a < 14'h2800) m_tile[a - 14'h2000] = d;
        end
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        check("R2 ack single", {31'd0, ack}, 32'd0);
    endtask

    task automatic wr(input logic [13:0] a, input logic [7:0] d);
        logic [7:0] r;
        bus(1'b1, a, d, r);
    endtask

    task automatic rd_expect(string req, input logic [13:0] a, input logic [7:0] e);
        logic [7:0] r;
        bus(1'b0, a, 8'h00, r);
        check(req, {24'd0, r}, {24'd0, e});
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int lo, per;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 ack in reset", {31'd0, ack}, 32'd0);
        check("R1 pix in reset", {31'd0, pix}, 32'd0);
        check("R1 hsync in reset", {31'd0, hsync}, 32'd1);
        check("R1 vsync in reset", {31'd0, vsync}, 32'd1);
        rst_n = 1'b1;

        // R2: request held for two cycles still yields one ack cycle
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 14'h0000;
        @(negedge clk);
        check("R2 held ack high", {31'd0, ack}, 32'd1);
        @(negedge clk);
        check("R2 held ack low", {31'd0, ack}, 32'd0);
        cyc = 1'b0; stb = 1'b0;

        // R6: power-up tile content
        rd_expect("R6 tile 0x41 row 3", 14'h2000 + 14'h41 * 8 + 3, glyph(8'h41, 3));
        rd_expect("R6 tile 0x7E row 7", 14'h2000 + 14'h7E * 8 + 7, glyph(8'h7E, 7));
        rd_expect("R6 space blank", 14'h2000 + 14'h20 * 8 + 2, 8'h00);
        rd_expect("R6 tile 0xFF blank", 14'h27FF, 8'h00);

        // R3: cell map readback and beyond-grid behaviour
        wr(14'd3, 8'hA5);
        rd_expect("R3 cell readback", 14'd3, 8'hA5);
        wr(14'(NCELL), 8'h5A);
        rd_expect("R3 beyond grid reads zero", 14'(NCELL), 8'h00);
        rd_expect("R3 cell 0 untouched", 14'd0, 8'h00);

        // R4: tile window readback, both ends
        wr(14'h27FF, 8'h3C);
        rd_expect("R4 last tile byte", 14'h27FF, 8'h3C);
        wr(14'h2000, 8'hC3);
        rd_expect("R4 first tile byte", 14'h2000, 8'hC3);

        // R5: unmapped addresses
        wr(14'h2800, 8'h77);
        rd_expect("R5 0x2800 reads zero", 14'h2800, 8'h00);
        wr(14'h3FFF, 8'h11);
        rd_expect("R5 0x3FFF reads zero", 14'h3FFF, 8'h00);
        rd_expect("R5 tile below untouched", 14'h27FF, 8'h3C);

        // R8: fill the grid with mixed glyphs and a custom tile
        wr(14'd0, 8'h41); wr(14'd1, 8'h20); wr(14'd2, 8'h7E); wr(14'd3, 8'h80);
        wr(14'd4, 8'h21); wr(14'd5, 8'h00); wr(14'd6, 8'h5A); wr(14'd7, 8'h80);
        for (int r = 0; r < 8; r++) wr(14'h2400 + 14'(r), 8'(8'h80 >> r) | 8'h01);
        repeat (12) @(negedge clk);
        cmp_en = 1'b1;
        repeat (2 * HT * VT * CPP) @(negedge clk);

        // Rewrite the custom tile while outputs are not compared, then recheck
        cmp_en = 1'b0;
        for (int r = 0; r < 8; r++) wr(14'h2400 + 14'(r), 8'hF0 ^ 8'(r));
        wr(14'd0, 8'h80);
        repeat (12) @(negedge clk);
        cmp_en = 1'b1;
        repeat (HT * VT * CPP + 50) @(negedge clk);
        cmp_en = 1'b0;

        // R11: sync width and line period in clocks
        while (hsync !== 1'b1) @(negedge clk);
        while (hsync !== 1'b0) @(negedge clk);
        lo = 0;
        while (hsync === 1'b0) begin lo++; @(negedge clk); end
        check("R11 hsync width clocks", 32'(lo), 32'(HS * CPP));
        per = lo;
        while (hsync === 1'b1) begin per++; @(negedge clk); end
        check("R11 line period clocks", 32'(per), 32'(HT * CPP));

        done = 1'b1;
        finish_run();
    end

endmodule